// File: doc/BRIEF.md
# Camera Packet Sequence Validator

This block sits behind a camera serial link's packet decoder and watches the stream of packet headers. Each header gives a 6-bit data type and a flag that says whether the packet is long or short. From this the block tracks whether the stream is idle or inside a frame. It counts the lines of the current frame, where one line is one long packet. When the frame closes, it reports the line count and a one-cycle completion pulse. Any header that breaks the expected frame structure raises a sequence-error pulse, together with a cause code.

Line start and line end markers are optional. When they are used, they must alternate correctly. Generic short packets may sit between lines without being treated as errors, and a pulse is raised for each one accepted inside a frame. Idle stretches between headers, such as low-power gaps on the link, leave the state alone.

The header input is a valid/ready stream. The block never applies back-pressure: `hdr_ready` is high in every cycle after reset. A header is accepted on any rising edge where `hdr_valid` is high. The upstream decoder may hold `hdr_valid` low for any number of cycles. All status outputs are plain registered signals.

Top module: `csi_frame_seq_checker`

## Requirements
- R1: After reset, `in_frame`, `line_count`, `frame_lines`, `frame_done`, `gen_seen`, `seq_err` and `err_kind` are all zero.
- R2: A frame start header (short, data type 0x00) accepted while idle sets `in_frame` and clears `line_count` to 0.
- R3: Each long header accepted inside a frame adds one to `line_count`. The count saturates at its maximum value, 2^LINE_W-1.
- R4: A frame end header (short, data type 0x01) accepted inside a frame has three effects: `frame_done` pulses for exactly one cycle, `frame_lines` takes the frame's line count, and `in_frame` clears.
- R5: A long header or a frame end header accepted while idle pulses `seq_err` with `err_kind` = 3'b001 (orphan). `line_count` and `frame_lines` are left unchanged, and `frame_done` does not pulse.
- R6: A frame start header accepted inside a frame pulses `seq_err` with `err_kind` = 3'b010 (nested). The frame restarts: `in_frame` stays high and `line_count` returns to 0.
- R7: A frame made only of a frame start, long headers and a frame end raises no `seq_err`. Line markers are not required.
- R8: Inside a frame, the following pulse `seq_err` with `err_kind` = 3'b100 (pairing): a line start (short, 0x02) while a line is already open, a line end (short, 0x03) with no open line start, and a frame end while a line start is open. Line markers while idle are ignored.
- R9: A generic short header (data types 0x08 to 0x0F) accepted inside a frame pulses `gen_seen` for one cycle and changes neither `line_count` nor `in_frame`. Outside a frame, `gen_seen` stays low.
- R10: Cycles with `hdr_valid` low change no state and raise no pulse.
- R11: `hdr_ready` is high in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_ready | output | 1 | Header accepted; high whenever out of reset |
| hdr_dtype | input | 6 | Data type of the header |
| hdr_long | input | 1 | 1 for a long packet, 0 for a short one |
| in_frame | output | 1 | Stream is between frame start and frame end |
| line_count | output | LINE_W | Lines counted so far in the current frame |
| frame_lines | output | LINE_W | Line count of the last completed frame |
| frame_done | output | 1 | One-cycle pulse on a valid frame end |
| gen_seen | output | 1 | One-cycle pulse on a generic short header inside a frame |
| seq_err | output | 1 | One-cycle pulse on a sequence violation |
| err_kind | output | 3 | Cause with `seq_err`: bit0 orphan, bit1 nested, bit2 pairing |

## Verification
Every result is registered once. It becomes visible just after the rising edge that accepts the header, and each pulse lasts until the next edge. The bench drives a header on a falling edge and removes it on the next falling edge. It then checks the outputs at that point, half a cycle after the accepting edge and inside the pulse window. Idle cycles are checked by letting several edges pass with `hdr_valid` low, then confirming that nothing moved.

// File: rtl/csi_seq_pkg.sv
package csi_seq_pkg;

  localparam int DT_W = 6;

  typedef enum logic [2:0] {
    K_FSTART,
    K_FEND,
    K_LSTART,
    K_LEND,
    K_GENERIC,
    K_LINE,
    K_OTHER
  } pkt_kind_e;

  localparam logic [2:0] ERR_ORPHAN  = 3'b001;
  localparam logic [2:0] ERR_NESTED  = 3'b010;
  localparam logic [2:0] ERR_PAIRING = 3'b100;

  function automatic pkt_kind_e classify(input logic [DT_W-1:0] dt, input logic is_long);
    if (is_long) return K_LINE;
    case (dt)
      6'h00:   return K_FSTART;
      6'h01:   return K_FEND;
      6'h02:   return K_LSTART;
      6'h03:   return K_LEND;
      default: return (dt[5:3] == 3'b001) ? K_GENERIC : K_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/csi_hdr_classify.sv
module csi_hdr_classify
  import csi_seq_pkg::*;
(
  input  logic [DT_W-1:0] dtype,
  input  logic            is_long,
  output pkt_kind_e       kind
);
  always_comb kind = classify(dtype, is_long);
endmodule

// File: rtl/csi_frame_fsm.sv
module csi_frame_fsm
  import csi_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  pkt_kind_e kind,
  output logic      in_frame,
  output logic      cnt_clr,
  output logic      cnt_inc,
  output logic      cnt_latch,
  output logic      done_p,
  output logic      gen_p,
  output logic [2:0] err_p
);
  logic ls_open;

  always_comb begin
    cnt_clr   = take && (kind == K_FSTART);
    cnt_inc   = take && (kind == K_LINE) && in_frame;
    cnt_latch = take && (kind == K_FEND) && in_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      ls_open  <= 1'b0;
      done_p   <= 1'b0;
      gen_p    <= 1'b0;
      err_p    <= '0;
    end else begin
      done_p <= 1'b0;
      gen_p  <= 1'b0;
      err_p  <= '0;
      if (take) begin
        case (kind)
          K_FSTART: begin
            if (in_frame) err_p <= ERR_NESTED;
            in_frame <= 1'b1;
            ls_open  <= 1'b0;
          end
          K_FEND: begin
            if (in_frame) begin
              done_p   <= 1'b1;
              in_frame <= 1'b0;
              ls_open  <= 1'b0;
              if (ls_open) err_p <= ERR_PAIRING;
            end else begin
              err_p <= ERR_ORPHAN;
            end
          end
          K_LINE: begin
            if (!in_frame) err_p <= ERR_ORPHAN;
          end
          K_LSTART: begin
            if (in_frame) begin
              if (ls_open) err_p <= ERR_PAIRING;
              ls_open <= 1'b1;
            end
          end
          K_LEND: begin
            if (in_frame) begin
              if (!ls_open) err_p <= ERR_PAIRING;
              ls_open <= 1'b0;
            end
          end
          K_GENERIC: begin
            if (in_frame) gen_p <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/csi_line_counter.sv
module csi_line_counter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              latch,
  output logic [LINE_W-1:0] count,
  output logic [LINE_W-1:0] held
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      held  <= '0;
    end else begin
      if (clr)                         count <= '0;
      else if (inc && count != CNT_MAX) count <= count + 1'b1;
      if (latch) held <= count;
    end
  end
endmodule

// File: rtl/csi_frame_seq_checker.sv
module csi_frame_seq_checker
  import csi_seq_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [5:0]        hdr_dtype,
  input  logic              hdr_long,
  output logic              in_frame,
  output logic [LINE_W-1:0] line_count,
  output logic [LINE_W-1:0] frame_lines,
  output logic              frame_done,
  output logic              gen_seen,
  output logic              seq_err,
  output logic [2:0]        err_kind
);
  pkt_kind_e kind;
  logic      take, clr, inc, latch;
  logic      rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign hdr_ready = rdy_q;
  assign take      = hdr_valid && rdy_q;

  csi_hdr_classify u_cls (
    .dtype  (hdr_dtype),
    .is_long(hdr_long),
    .kind   (kind)
  );

  csi_frame_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .kind     (kind),
    .in_frame (in_frame),
    .cnt_clr  (clr),
    .cnt_inc  (inc),
    .cnt_latch(latch),
    .done_p   (frame_done),
    .gen_p    (gen_seen),
    .err_p    (err_kind)
  );

  csi_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .inc  (inc),
    .latch(latch),
    .count(line_count),
    .held (frame_lines)
  );

  assign seq_err = |err_kind;
endmodule

// File: rtl/csi_frame_seq_checker_sva.sv
module csi_frame_seq_checker_sva #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic              in_frame,
  input logic [LINE_W-1:0] line_count,
  input logic [LINE_W-1:0] frame_lines,
  input logic              frame_done,
  input logic              gen_seen,
  input logic              seq_err,
  input logic [2:0]        err_kind
);
  p_done_onecycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !in_frame);

  p_nested_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_kind[1] |-> (in_frame && line_count == '0));

  p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ready && !hdr_valid) |=> (!frame_done && !seq_err && !gen_seen));

  p_gap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ready && !hdr_valid) |=> ($stable(line_count) && $stable(in_frame) && $stable(frame_lines)));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |=> (line_count == $past(line_count) || line_count == $past(line_count) + 1'b1
                   || line_count == '0));

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |=> hdr_ready);
endmodule

bind csi_frame_seq_checker csi_frame_seq_checker_sva #(.LINE_W(LINE_W)) u_sva (.*);

// File: tb/csi_frame_seq_checker_tb.sv
module csi_frame_seq_checker_tb;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hdr_valid = 1'b0;
  logic [5:0]    hdr_dtype = '0;
  logic          hdr_long = 1'b0;
  logic          hdr_ready, in_frame, frame_done, gen_seen, seq_err;
  logic [LW-1:0] line_count, frame_lines;
  logic [2:0]    err_kind;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  csi_frame_seq_checker #(.LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dtype(hdr_dtype), .hdr_long(hdr_long), .in_frame(in_frame),
    .line_count(line_count), .frame_lines(frame_lines), .frame_done(frame_done),
    .gen_seen(gen_seen), .seq_err(seq_err), .err_kind(err_kind)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] dt, input logic lng);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dtype = dt; hdr_long = lng;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "in_frame", int'(in_frame), 0);
    chk("R1", "line_count", int'(line_count), 0);
    chk("R1", "frame_lines", int'(frame_lines), 0);
    chk("R1", "pulses", int'({frame_done, gen_seen, seq_err}), 0);
    chk("R1", "err_kind", int'(err_kind), 0);
    chk("R11", "hdr_ready", int'(hdr_ready), 1);
  endtask

  task automatic t_plain;
    send(6'h00, 0);
    chk("R2", "in_frame after start", int'(in_frame), 1);
    chk("R2", "count after start", int'(line_count), 0);
    for (int i = 0; i < 3; i++) begin
      send(6'h24, 1);
      chk("R7", "no error on line", int'(seq_err), 0);
      gap(2);
    end
    chk("R3", "count after 3 lines", int'(line_count), 3);
    send(6'h01, 0);
    chk("R4", "frame_done", int'(frame_done), 1);
    chk("R4", "frame_lines", int'(frame_lines), 3);
    chk("R4", "in_frame after end", int'(in_frame), 0);
    chk("R7", "no error on end", int'(seq_err), 0);
    gap(1);
    chk("R4", "frame_done one cycle", int'(frame_done), 0);
  endtask

  task automatic t_generic;
    send(6'h08, 0);
    chk("R9", "gen_seen idle", int'(gen_seen), 0);
    send(6'h00, 0);
    for (int l = 0; l < 2; l++) begin
      send(6'h08, 0);
      chk("R9", "gen_seen", int'(gen_seen), 1);
      chk("R9", "count on generic", int'(line_count), l);
      send(6'h0F, 0);
      chk("R9", "gen_seen 0x0F", int'(gen_seen), 1);
      chk("R9", "in_frame on generic", int'(in_frame), 1);
      send(6'h24, 1);
      chk("R9", "gen_seen after line", int'(gen_seen), 0);
    end
    send(6'h01, 0);
    chk("R9", "lines with generics", int'(frame_lines), 2);
    chk("R9", "no error", int'(seq_err), 0);
  endtask

  task automatic t_orphan;
    send(6'h24, 1);
    chk("R5", "seq_err on idle line", int'(seq_err), 1);
    chk("R5", "err_kind orphan", int'(err_kind), 1);
    chk("R5", "count unchanged", int'(line_count), 2);
    send(6'h01, 0);
    chk("R5", "seq_err on idle end", int'(seq_err), 1);
    chk("R5", "err_kind orphan end", int'(err_kind), 1);
    chk("R5", "no frame_done", int'(frame_done), 0);
    chk("R5", "frame_lines held", int'(frame_lines), 2);
  endtask

  task automatic t_nested;
    send(6'h00, 0);
    send(6'h24, 1);
    send(6'h24, 1);
    send(6'h00, 0);
    chk("R6", "seq_err nested", int'(seq_err), 1);
    chk("R6", "err_kind nested", int'(err_kind), 2);
    chk("R6", "in_frame kept", int'(in_frame), 1);
    chk("R6", "count restarted", int'(line_count), 0);
    send(6'h24, 1);
    send(6'h01, 0);
    chk("R6", "lines after restart", int'(frame_lines), 1);
  endtask

  task automatic t_pairing;
    send(6'h02, 0);
    chk("R8", "idle line start ignored", int'(seq_err), 0);
    send(6'h00, 0);
    send(6'h02, 0);
    chk("R8", "first line start ok", int'(seq_err), 0);
    send(6'h24, 1);
    send(6'h03, 0);
    chk("R8", "matched line end ok", int'(seq_err), 0);
    send(6'h02, 0);
    send(6'h02, 0);
    chk("R8", "double line start", int'(err_kind), 4);
    send(6'h03, 0);
    chk("R8", "line end closes", int'(seq_err), 0);
    send(6'h03, 0);
    chk("R8", "lone line end", int'(err_kind), 4);
    send(6'h02, 0);
    send(6'h01, 0);
    chk("R8", "end with open line", int'(err_kind), 4);
    chk("R8", "frame_done still", int'(frame_done), 1);
    chk("R8", "lines", int'(frame_lines), 1);
  endtask

  task automatic t_gaps;
    send(6'h00, 0);
    send(6'h24, 1);
    gap(6);
    chk("R10", "count across gap", int'(line_count), 1);
    chk("R10", "in_frame across gap", int'(in_frame), 1);
    chk("R10", "no pulses in gap", int'({frame_done, gen_seen, seq_err}), 0);
    send(6'h01, 0);
    chk("R10", "lines after gap", int'(frame_lines), 1);
  endtask

  task automatic t_saturate;
    send(6'h00, 0);
    for (int i = 0; i < 20; i++) send(6'h24, 1);
    chk("R3", "saturated count", int'(line_count), 15);
    send(6'h01, 0);
    chk("R3", "saturated frame_lines", int'(frame_lines), 15);
  endtask

  task automatic finish_run;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    gap(3);
    rst_n = 1'b1;
    gap(2);
    t_reset();
    t_plain();
    t_generic();
    t_orphan();
    t_nested();
    t_pairing();
    t_gaps();
    t_saturate();
    gap(2);
    finish_run();
  end
endmodule